// File: doc/BRIEF.md
# Shared SRAM Byte/Word Access Port

This block sits between a 32-bit processor data port, a display refresh reader and one word-wide static RAM. All three share a single address bus. On every cycle the block decides who owns the RAM. A pending display fetch always wins, and the processor is stalled while it waits. The block then forms the RAM word address, steers the byte lanes and produces the active-low control strobes.

Processor addresses are byte addresses. The RAM only sees the word part, because the two lowest address bits are dropped from the word address. A word access whose address is not a multiple of four is not flagged. It reaches the word that contains that byte. A byte access uses the two low bits to pick a lane. On a load, that lane is returned zero-extended. On a store, the byte is copied onto every lane and only the chosen lane's enable is driven. Byte and word accesses both finish in the cycle they are granted.

Top module: `sramSharedPort`

## Requirements
- R1: When `dispReq` is low, `sramAdr` equals `cpuAdr[19:2]`.
- R2: When `dispReq` is high, `sramAdr` equals `vidAdr`, and `cpuStall` equals `cpuReq`.
- R3: A granted word load returns `sramDin` unchanged on `cpuRdata`, whatever the value of `cpuAdr[1:0]`.
- R4: A granted byte load returns on `cpuRdata` the lane `k = cpuAdr[1:0]` (lane k is `sramDin[8k+7:8k]`), zero-extended to 32 bits.
- R5: A granted byte store drives `sramDout = {4{cpuWdata[7:0]}}` and `sramWeN = 0`. It also drives `sramBeN` low only on bit `cpuAdr[1:0]`, with the other three bits high.
- R6: A granted word store drives `sramDout = cpuWdata`, `sramBeN = 4'b0000` and `sramWeN = 0`.
- R7: During a display fetch, `sramWeN = 1`, `sramBeN = 4'b0000`, `sramOeN = 0` and `sramCeN = 0`, and `vidRdata` equals `sramDin`.
- R8: With neither request active, `sramCeN`, `sramOeN` and `sramWeN` are all 1, and `sramBeN = 4'b1111`.
- R9: A granted processor load drives `sramCeN = 0`, `sramOeN = 0`, `sramWeN = 1` and `sramBeN = 4'b0000`. A granted processor store drives `sramOeN = 1`.
- R10: While `dispReq` is low, `cpuStall` is 0 for byte and word accesses alike. No access adds a wait state.
- R11: In the first cycle after `dispReq` falls, a processor request that is still pending is granted. Its strobes appear in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used by the sequencing checks |
| rstN | input | 1 | Active-low reset |
| cpuReq | input | 1 | Processor memory request |
| cpuWe | input | 1 | 1 = store, 0 = load |
| cpuByte | input | 1 | 1 = byte access, 0 = word access |
| cpuAdr | input | 20 | Processor byte address |
| cpuWdata | input | 32 | Processor store data |
| cpuRdata | output | 32 | Processor load data |
| cpuStall | output | 1 | Processor must hold its request |
| dispReq | input | 1 | Display fetch request (top priority) |
| vidAdr | input | 18 | Display word address |
| vidRdata | output | 32 | Display fetch data |
| sramAdr | output | 18 | RAM word address |
| sramDout | output | 32 | Data driven to the RAM |
| sramDin | input | 32 | Data read from the RAM |
| sramBeN | output | 4 | Active-low byte enables |
| sramWeN | output | 1 | Active-low write enable |
| sramCeN | output | 1 | Active-low chip enable |
| sramOeN | output | 1 | Active-low output enable |

## Verification
A display fetch and a processor access can both be requested in the same cycle. The bench provokes this by raising `cpuReq` together with `dispReq`, across loads, stores, byte and word modes and all four low-address values. In each such cycle the display must own the address and the strobes, and no write strobe may leak from the held store. The processor must see a stall. In the cycle after `dispReq` drops, the behavioural model expects the held access to go through with its own lane strobes.

// File: rtl/sramPortPkg.sv
package sramPortPkg;
  typedef struct packed {
    logic cpuGrant;
    logic vidGrant;
    logic doWrite;
    logic byteMode;
  } portStrobes_t;
endpackage

// File: rtl/sramPortCtrl.sv
module sramPortCtrl
  import sramPortPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cpuReq,
  input  logic         cpuWe,
  input  logic         cpuByte,
  input  logic         dispReq,
  output logic         cpuStall,
  output portStrobes_t strobes
);
  logic heldQ;

  always_comb begin
    strobes.vidGrant = dispReq;
    strobes.cpuGrant = cpuReq && !dispReq;
    strobes.doWrite  = cpuWe;
    strobes.byteMode = cpuByte;
    cpuStall         = cpuReq && dispReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) heldQ <= 1'b0;
    else       heldQ <= cpuReq && dispReq;
  end

  // R11: a request held under display is granted once display drops
  assert_held_release_R11: assert property (@(posedge clk) disable iff (!rstN)
    (heldQ && !dispReq && cpuReq) |-> (strobes.cpuGrant && !cpuStall));

  // R2: a cycle that stalls the processor never grants it
  assert_stall_excl_R2: assert property (@(posedge clk) disable iff (!rstN)
    cpuStall |-> (!strobes.cpuGrant && strobes.vidGrant));

  // R10: no stall without display ownership
  assert_no_wait_R10: assert property (@(posedge clk) disable iff (!rstN)
    !dispReq |-> !cpuStall);
endmodule

// File: rtl/sramPortDatapath.sv
module sramPortDatapath
  import sramPortPkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 32,
  localparam int LANES     = DATA_W / 8,
  localparam int LANE_BITS = $clog2(LANES),
  localparam int WORD_AW   = ADDR_W - LANE_BITS
)(
  input  logic                clk,
  input  logic                rstN,
  input  portStrobes_t        strobes,
  input  logic [ADDR_W-1:0]   cpuAdr,
  input  logic [DATA_W-1:0]   cpuWdata,
  output logic [DATA_W-1:0]   cpuRdata,
  input  logic [WORD_AW-1:0]  vidAdr,
  output logic [DATA_W-1:0]   vidRdata,
  output logic [WORD_AW-1:0]  sramAdr,
  output logic [DATA_W-1:0]   sramDout,
  input  logic [DATA_W-1:0]   sramDin,
  output logic [LANES-1:0]    sramBeN,
  output logic                sramWeN,
  output logic                sramCeN,
  output logic                sramOeN
);
  logic [LANE_BITS-1:0] laneSel;
  logic [7:0]           laneBytes [LANES];
  logic [LANES-1:0]     laneHot;
  logic                 cpuStore;

  assign laneSel  = cpuAdr[LANE_BITS-1:0];
  assign cpuStore = strobes.cpuGrant && strobes.doWrite;

  for (genvar k = 0; k < LANES; k++) begin : gLane
    assign laneBytes[k] = sramDin[8*k +: 8];
    assign laneHot[k]   = (laneSel == LANE_BITS'(k));
  end

  always_comb begin
    sramAdr = strobes.vidGrant ? vidAdr : cpuAdr[ADDR_W-1:LANE_BITS];
    sramDout = strobes.byteMode ? {LANES{cpuWdata[7:0]}} : cpuWdata;
    cpuRdata = strobes.byteMode ? DATA_W'(laneBytes[laneSel]) : sramDin;
    vidRdata = sramDin;
    sramCeN = !(strobes.vidGrant || strobes.cpuGrant);
    sramWeN = !cpuStore;
    sramOeN = !(strobes.vidGrant || (strobes.cpuGrant && !strobes.doWrite));
    if (strobes.vidGrant)                          sramBeN = '0;
    else if (cpuStore && strobes.byteMode)         sramBeN = ~laneHot;
    else if (strobes.cpuGrant)                     sramBeN = '0;
    else                                           sramBeN = '1;
  end

  // R7: display fetch is a read with all lanes on
  assert_vid_read_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.vidGrant |-> (sramWeN && !sramOeN && !sramCeN && sramBeN == '0));

  // R5: a byte store enables exactly one lane
  assert_one_lane_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cpuStore && strobes.byteMode) |-> ($countones(~sramBeN) == 1));

  // R8: idle port drives no strobe
  assert_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.vidGrant && !strobes.cpuGrant) |-> (sramCeN && sramOeN && sramWeN));

  // R9: never read and write enable together
  assert_oe_we_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(!sramOeN && !sramWeN));
endmodule

// File: rtl/sramSharedPort.sv
module sramSharedPort
  import sramPortPkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 32,
  localparam int LANES   = DATA_W / 8,
  localparam int WORD_AW = ADDR_W - $clog2(LANES)
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               cpuReq,
  input  logic               cpuWe,
  input  logic               cpuByte,
  input  logic [ADDR_W-1:0]  cpuAdr,
  input  logic [DATA_W-1:0]  cpuWdata,
  output logic [DATA_W-1:0]  cpuRdata,
  output logic               cpuStall,
  input  logic               dispReq,
  input  logic [WORD_AW-1:0] vidAdr,
  output logic [DATA_W-1:0]  vidRdata,
  output logic [WORD_AW-1:0] sramAdr,
  output logic [DATA_W-1:0]  sramDout,
  input  logic [DATA_W-1:0]  sramDin,
  output logic [LANES-1:0]   sramBeN,
  output logic               sramWeN,
  output logic               sramCeN,
  output logic               sramOeN
);
  portStrobes_t strobes;

  sramPortCtrl uCtrl (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe),
    .cpuByte(cpuByte), .dispReq(dispReq), .cpuStall(cpuStall),
    .strobes(strobes)
  );

  sramPortDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cpuAdr(cpuAdr),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .vidAdr(vidAdr),
    .vidRdata(vidRdata), .sramAdr(sramAdr), .sramDout(sramDout),
    .sramDin(sramDin), .sramBeN(sramBeN), .sramWeN(sramWeN),
    .sramCeN(sramCeN), .sramOeN(sramOeN)
  );
endmodule

// File: tb/sim_sramSharedPort.sv
`timescale 1ns/1ps
module sim_sramSharedPort;
  logic clk = 0, rstN = 0;
  logic cpuReq = 0, cpuWe = 0, cpuByte = 0, dispReq = 0;
  logic [19:0] cpuAdr = 0;
  logic [31:0] cpuWdata = 0, sramDin = 0;
  logic [17:0] vidAdr = 0;
  logic [31:0] cpuRdata, vidRdata, sramDout;
  logic cpuStall, sramWeN, sramCeN, sramOeN;
  logic [17:0] sramAdr;
  logic [3:0] sramBeN;
  int compared = 0, mismatched = 0;
  logic prevDisp = 0;

  always #2 clk = ~clk;

  sramSharedPort u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural reference, evaluated at the negative edge
  task automatic model();
    int k;
    bit grantCpu;
    bit [31:0] rd;
    k = int'(cpuAdr[1:0]);
    grantCpu = cpuReq && !dispReq;
    if (dispReq) begin
      chk("R2 adr", 32'(sramAdr), 32'(vidAdr));
      chk("R2 stall", 32'(cpuStall), 32'(cpuReq));
      chk("R7 strobes", {sramWeN, sramOeN, sramCeN, sramBeN}, {1'b1, 1'b0, 1'b0, 4'b0000});
      chk("R7 data", vidRdata, sramDin);
    end else begin
      chk("R1 adr", 32'(sramAdr), 32'(cpuAdr / 4));
      chk("R10 stall", 32'(cpuStall), 0);
      if (!cpuReq)
        chk("R8 idle", {sramWeN, sramOeN, sramCeN, sramBeN}, {1'b1, 1'b1, 1'b1, 4'b1111});
    end
    if (grantCpu) begin
      if (prevDisp) chk("R11 release", {cpuStall, sramCeN}, 0);
      if (!cpuWe) begin
        chk("R9 load strobes", {sramWeN, sramOeN, sramCeN, sramBeN}, {1'b1, 1'b0, 1'b0, 4'b0000});
        if (cpuByte) begin
          rd = (sramDin >> (8 * k)) & 32'hFF;
          chk("R4 byte load", cpuRdata, rd);
        end else chk("R3 word load", cpuRdata, sramDin);
      end else begin
        chk("R9 store oe", 32'(sramOeN), 1);
        if (cpuByte) begin
          chk("R5 data", sramDout, {4{cpuWdata[7:0]}});
          chk("R5 strobes", {sramWeN, sramBeN}, {1'b0, 4'b1111 ^ (4'b1 << k)});
        end else begin
          chk("R6 data", sramDout, cpuWdata);
          chk("R6 strobes", {sramWeN, sramBeN}, {1'b0, 4'b0000});
        end
      end
    end
  endtask

  task automatic drive(input bit r, input bit w, input bit b, input bit d,
                       input logic [19:0] a, input logic [31:0] wd, input logic [31:0] din);
    cpuReq = r; cpuWe = w; cpuByte = b; dispReq = d;
    cpuAdr = a; cpuWdata = wd; sramDin = din; vidAdr = 18'(a ^ 20'h2A5C4);
    @(negedge clk);
    model();
    prevDisp = dispReq;
    @(posedge clk); #1;
  endtask

  initial begin
    #(4 * 200000);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk("R8 reset idle", {sramWeN, sramOeN, sramCeN, sramBeN, cpuStall}, {1'b1, 1'b1, 1'b1, 4'b1111, 1'b0});
    repeat (2) @(posedge clk);
    #1 rstN = 1;
    // R3: every low-bit offset gives the same word
    for (int a = 0; a < 4; a++) drive(1, 0, 0, 0, 20'h01230 + 20'(a), 0, 32'h07060504);
    // R4: each byte lane
    for (int a = 0; a < 4; a++) drive(1, 0, 1, 0, 20'h00404 + 20'(a), 0, 32'hA1B2C3D4);
    // R5 and R6 stores
    for (int a = 0; a < 4; a++) drive(1, 1, 1, 0, 20'hFFFF8 + 20'(a), 32'h123456E7, 0);
    drive(1, 1, 0, 0, 20'h00013, 32'hCAFEF00D, 0);
    // R2 collision then R11 release, store held under display
    drive(1, 1, 1, 1, 20'h00102, 32'h5A, 32'h11);
    drive(1, 1, 1, 1, 20'h00102, 32'h5A, 32'h22);
    drive(1, 1, 1, 0, 20'h00102, 32'h5A, 32'h33);
    drive(1, 0, 1, 1, 20'h00203, 0, 32'h88776655);
    drive(1, 0, 1, 0, 20'h00203, 0, 32'h88776655);
    drive(0, 0, 0, 1, 0, 0, 32'hDEAD);
    drive(0, 0, 0, 0, 0, 0, 32'hBEEF);
    for (int i = 0; i < 3000; i++)
      drive($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
            ($urandom_range(0, 3) == 0), 20'($urandom), $urandom, $urandom);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule